// File: doc/BRIEF.md
# Network Controller Host Command Front End

This block is the register face of a DMA network controller on a 16-bit host bus. The host sees four word registers: control/status, DMA address low, byte count, and DMA address high. The host sets up an address and a length, then writes a 6-bit function code into the control/status word with the go bit set. Some codes run inside the block: they queue a receive buffer, flush that queue, or reset the front end. Every other defined code is handed to a back end, which stands in for the MAC and the DMA engine, over a one-cycle request and a done/status reply. A code outside the defined set is rejected at once.

The receive-buffer queue holds up to sixteen descriptors. Each descriptor is a 22-bit address and a 16-bit length. The back end consumes the head entry when it signals that a receive DMA has finished. There are two completion flags, one for commands and one for receives, and each has its own enable. The block drives one interrupt request line per flag and a vector number. The vector is the base when a receive is pending and the base plus 4 when only a command completion is pending.

Top module: `nic_cmd_frontend`

## Requirements
- R1: `bus_word` selects a register: 0 control/status, 1 address low, 2 byte count, 3 address high. A control/status read returns {bit15 0, bit14 busy, bits13:8 last accepted code, bit7 command done, bit6 command enable, bit5 receive done, bit4 receive enable, bits3:0 status}. After reset that word reads 0, both requests are low and the queue is empty.
- R2: Reads of the address low (word 1) and byte count (word 2) registers return 0, whatever was written to them.
- R3: The address high register keeps bits 5:0 of the written data, and those bits read back on word 3 with bits 15:6 at 0. A descriptor address is {address high[5:0], address low[15:0]}.
- R4: Code 40 octal, when the queue is not full, appends {current 22-bit address, byte count} at the tail of the queue. It completes on the next cycle with status 0. Descriptors leave in the order they were added, and the queue holds 16.
- R5: Code 40 octal with 16 entries queued completes with status 3 and leaves the queue, including its head, unchanged.
- R6: Code 60 octal empties the queue and completes with status 0.
- R7: Code 77 octal empties the queue and clears receive done and all three address/count registers. It completes with status 0.
- R8: A go write of a code outside the defined set (for example 13, 24, 41 or 70 octal) completes on the next cycle with status 2, and no back-end request is made.
- R9: A go write of any other defined code raises `be_cmd_valid` for exactly one cycle, with `be_cmd_code` equal to the code, and sets busy. The cycle after `be_done`, command done is 1, busy is 0 and the status equals `be_status`. Go writes made while busy are ignored.
- R10: An accepted go write clears command done. A control/status write with bit 15 clear leaves command done, status and code unchanged, and loads the two enables from bits 6 and 4.
- R11: `rx_event` with a non-empty queue removes the head entry and sets receive done. `rx_event` with an empty queue changes nothing. Writing control/status with bit 5 at 0 clears receive done, and writing it at 1 keeps it.
- R12: `irq_cmd` is high exactly while command done and its enable are both set, and `irq_rx` is high exactly while receive done and its enable are both set. `irq_vector` is VEC_BASE (default 340 octal) unless only `irq_cmd` is high, in which case it is VEC_BASE+4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Host write strobe, one cycle per write |
| bus_word | input | 2 | Register word index (byte offset / 2) |
| bus_wdata | input | 16 | Host write data |
| bus_rdata | output | 16 | Host read data for `bus_word` (combinational) |
| be_cmd_valid | output | 1 | One-cycle request to the back end |
| be_cmd_code | output | 6 | Function code of the back-end request |
| be_done | input | 1 | Back end finished the forwarded command |
| be_status | input | 4 | Completion status from the back end |
| rx_event | input | 1 | Receive DMA finished into the head buffer |
| rx_desc_valid | output | 1 | Queue holds at least one descriptor |
| rx_desc_addr | output | 22 | Head descriptor address |
| rx_desc_len | output | 16 | Head descriptor byte count |
| irq_cmd | output | 1 | Command-completion interrupt request |
| irq_rx | output | 1 | Receive-completion interrupt request |
| irq_vector | output | 9 | Vector number of the pending request |

## Verification
The bench fills the queue to exactly sixteen entries and then tries a seventeenth. A design with an off-by-one bound would either refuse the sixteenth descriptor or overwrite the head. The bench then drains the queue and checks addresses against the order they were written in, which catches a wrong pointer wrap. It issues a go write while a forwarded command is outstanding, and checks a pop on an empty queue and a host clear of receive done, each of which a careless design would let disturb its state. With both requests pending it checks that the vector prefers receive, so a swapped priority or a wrong offset of 4 shows up as a vector mismatch.

// File: rtl/nic_host_pkg.sv
package nic_host_pkg;

  typedef logic [5:0] func_t;
  typedef logic [3:0] stat_t;

  localparam func_t FN_RXBUF = 6'o40;
  localparam func_t FN_FLUSH = 6'o60;
  localparam func_t FN_RESET = 6'o77;

  localparam stat_t ST_OK       = 4'o00;
  localparam stat_t ST_ILLEGAL  = 4'o02;
  localparam stat_t ST_INAPPROP = 4'o03;

  typedef enum logic [1:0] {
    CK_ILLEGAL = 2'd0,
    CK_LOCAL   = 2'd1,
    CK_REMOTE  = 2'd2
  } cmd_kind_e;

  function automatic cmd_kind_e classify(func_t f);
    cmd_kind_e k;
    case (f)
      6'o40, 6'o60, 6'o77: k = CK_LOCAL;
      6'o01, 6'o02, 6'o03, 6'o04, 6'o05, 6'o06, 6'o07,
      6'o10, 6'o11, 6'o12, 6'o15, 6'o16, 6'o17,
      6'o20, 6'o21, 6'o22, 6'o23, 6'o30, 6'o31,
      6'o50, 6'o51, 6'o52, 6'o53, 6'o54: k = CK_REMOTE;
      default: k = CK_ILLEGAL;
    endcase
    return k;
  endfunction

endpackage

// File: rtl/rxq_fifo.sv
module rxq_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 38
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  input  logic         flush,
  output logic [W-1:0] head,
  output logic         not_empty,
  output logic         full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_q, wr_n, rd_q, rd_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          push_ok, pop_ok;

  assign not_empty = (cnt_q != '0);
  assign full      = (cnt_q == CW'(DEPTH));
  assign head      = mem[rd_q];

  always_comb begin
    push_ok = push && !full && !flush;
    pop_ok  = pop && not_empty && !flush;
    wr_n    = wr_q;
    rd_n    = rd_q;
    cnt_n   = cnt_q;
    if (flush) begin
      wr_n  = '0;
      rd_n  = '0;
      cnt_n = '0;
    end else begin
      if (push_ok) wr_n = (wr_q == LAST) ? '0 : wr_q + 1'b1;
      if (pop_ok)  rd_n = (rd_q == LAST) ? '0 : rd_q + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   cnt_n = cnt_q + 1'b1;
        2'b01:   cnt_n = cnt_q - 1'b1;
        default: cnt_n = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_n;
      rd_q  <= rd_n;
      cnt_q <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_q] <= wdata;
  end

  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));

  a_r6_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !not_empty);

endmodule

// File: rtl/cmd_ctl.sv
module cmd_ctl
  import nic_host_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  go,
  input  func_t go_code,
  input  logic  be_done,
  input  stat_t be_status,
  input  logic  q_full,
  output logic  cmd_done,
  output stat_t status,
  output logic  busy,
  output func_t last_code,
  output logic  be_cmd_valid,
  output logic  do_push,
  output logic  do_flush,
  output logic  do_reset
);
  logic      done_q, done_n, busy_q, busy_n, bev_q, bev_n;
  stat_t     stat_q, stat_n;
  func_t     code_q, code_n;
  logic      accept;
  cmd_kind_e kind;

  assign accept = go && !busy_q;
  assign kind   = classify(go_code);

  assign do_push  = accept && (go_code == FN_RXBUF) && !q_full;
  assign do_flush = accept && (go_code == FN_FLUSH);
  assign do_reset = accept && (go_code == FN_RESET);

  always_comb begin
    done_n = done_q;
    busy_n = busy_q;
    stat_n = stat_q;
    code_n = code_q;
    bev_n  = 1'b0;
    if (accept) begin
      code_n = go_code;
      case (kind)
        CK_LOCAL: begin
          done_n = 1'b1;
          stat_n = ((go_code == FN_RXBUF) && q_full) ? ST_INAPPROP : ST_OK;
        end
        CK_REMOTE: begin
          done_n = 1'b0;
          busy_n = 1'b1;
          bev_n  = 1'b1;
        end
        default: begin
          done_n = 1'b1;
          stat_n = ST_ILLEGAL;
        end
      endcase
    end else if (busy_q && be_done) begin
      busy_n = 1'b0;
      done_n = 1'b1;
      stat_n = be_status;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      busy_q <= 1'b0;
      stat_q <= ST_OK;
      code_q <= '0;
      bev_q  <= 1'b0;
    end else begin
      done_q <= done_n;
      busy_q <= busy_n;
      stat_q <= stat_n;
      code_q <= code_n;
      bev_q  <= bev_n;
    end
  end

  assign cmd_done     = done_q;
  assign status       = stat_q;
  assign busy         = busy_q;
  assign last_code    = code_q;
  assign be_cmd_valid = bev_q;

  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    be_cmd_valid |=> !be_cmd_valid);

  a_r9_completion: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && be_done) |=> (cmd_done && !busy && status == $past(be_status)));

  a_r9_ignore_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (go && busy && !be_done) |=> (busy && !cmd_done && $stable(last_code)));

  a_r8_illegal: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && kind == CK_ILLEGAL) |=> (cmd_done && status == ST_ILLEGAL && !be_cmd_valid));

  a_r5_full_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && go_code == FN_RXBUF && q_full) |=> (cmd_done && status == ST_INAPPROP));

endmodule

// File: rtl/irq_ctl.sv
module irq_ctl #(
  parameter int               VEC_W    = 9,
  parameter logic [VEC_W-1:0] VEC_BASE = 9'o340,
  parameter int               VEC_STEP = 4
) (
  input  logic             cmd_done,
  input  logic             cmd_ie,
  input  logic             rx_done,
  input  logic             rx_ie,
  output logic             irq_cmd,
  output logic             irq_rx,
  output logic [VEC_W-1:0] vector
);
  localparam logic [VEC_W-1:0] VEC_CMD = VEC_W'(VEC_BASE + VEC_STEP);

  always_comb begin
    irq_cmd = cmd_done && cmd_ie;
    irq_rx  = rx_done && rx_ie;
    vector  = (irq_cmd && !irq_rx) ? VEC_CMD : VEC_BASE;
  end

  always_comb begin
    if (irq_rx && irq_cmd) begin
      a_r12_rx_priority: assert (vector == VEC_BASE);
    end
  end

endmodule

// File: rtl/nic_cmd_frontend.sv
module nic_cmd_frontend
  import nic_host_pkg::*;
#(
  parameter int               BUS_W    = 16,
  parameter int               XA_W     = 6,
  parameter int               Q_DEPTH  = 16,
  parameter int               VEC_W    = 9,
  parameter logic [VEC_W-1:0] VEC_BASE = 9'o340
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_wr,
  input  logic [1:0]            bus_word,
  input  logic [BUS_W-1:0]      bus_wdata,
  output logic [BUS_W-1:0]      bus_rdata,
  output logic                  be_cmd_valid,
  output logic [5:0]            be_cmd_code,
  input  logic                  be_done,
  input  logic [3:0]            be_status,
  input  logic                  rx_event,
  output logic                  rx_desc_valid,
  output logic [XA_W+BUS_W-1:0] rx_desc_addr,
  output logic [BUS_W-1:0]      rx_desc_len,
  output logic                  irq_cmd,
  output logic                  irq_rx,
  output logic [VEC_W-1:0]      irq_vector
);
  localparam int AW     = XA_W + BUS_W;
  localparam int DESC_W = AW + BUS_W;
  localparam logic [1:0] W_CSR = 2'd0, W_BAL = 2'd1, W_CNT = 2'd2, W_BAH = 2'd3;

  logic rst_s1, rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s  <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s  <= rst_s1;
    end
  end

  logic [BUS_W-1:0] bal_q, bal_n, cnt_q, cnt_n;
  logic [XA_W-1:0]  bah_q, bah_n;
  logic             cie_q, cie_n, rie_q, rie_n, rxd_q, rxd_n;
  logic             wr_csr, go;
  logic             cmd_done, busy, q_full, do_push, do_flush, do_reset;
  stat_t            status;
  func_t            last_code;
  logic [DESC_W-1:0] head;

  assign wr_csr = bus_wr && (bus_word == W_CSR);
  assign go     = wr_csr && bus_wdata[15];

  cmd_ctl u_cmd (
    .clk          (clk),
    .rst_n        (rst_s),
    .go           (go),
    .go_code      (bus_wdata[13:8]),
    .be_done      (be_done),
    .be_status    (be_status),
    .q_full       (q_full),
    .cmd_done     (cmd_done),
    .status       (status),
    .busy         (busy),
    .last_code    (last_code),
    .be_cmd_valid (be_cmd_valid),
    .do_push      (do_push),
    .do_flush     (do_flush),
    .do_reset     (do_reset)
  );

  rxq_fifo #(.DEPTH(Q_DEPTH), .W(DESC_W)) u_rxq (
    .clk       (clk),
    .rst_n     (rst_s),
    .push      (do_push),
    .wdata     ({bah_q, bal_q, cnt_q}),
    .pop       (rx_event),
    .flush     (do_flush || do_reset),
    .head      (head),
    .not_empty (rx_desc_valid),
    .full      (q_full)
  );

  irq_ctl #(.VEC_W(VEC_W), .VEC_BASE(VEC_BASE), .VEC_STEP(4)) u_irq (
    .cmd_done (cmd_done),
    .cmd_ie   (cie_q),
    .rx_done  (rxd_q),
    .rx_ie    (rie_q),
    .irq_cmd  (irq_cmd),
    .irq_rx   (irq_rx),
    .vector   (irq_vector)
  );

  assign be_cmd_code  = last_code;
  assign rx_desc_addr = head[DESC_W-1:BUS_W];
  assign rx_desc_len  = head[BUS_W-1:0];

  always_comb begin
    bal_n = bal_q;
    cnt_n = cnt_q;
    bah_n = bah_q;
    cie_n = cie_q;
    rie_n = rie_q;
    rxd_n = rxd_q;
    if (bus_wr) begin
      case (bus_word)
        W_BAL:   bal_n = bus_wdata;
        W_CNT:   cnt_n = bus_wdata;
        W_BAH:   bah_n = bus_wdata[XA_W-1:0];
        default: begin
          cie_n = bus_wdata[6];
          rie_n = bus_wdata[4];
        end
      endcase
    end
    if (do_reset) begin
      bal_n = '0;
      cnt_n = '0;
      bah_n = '0;
      rxd_n = 1'b0;
    end else if (rx_event && rx_desc_valid && !do_flush) begin
      rxd_n = 1'b1;
    end else if (wr_csr && !bus_wdata[5]) begin
      rxd_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      bal_q <= '0;
      cnt_q <= '0;
      bah_q <= '0;
      cie_q <= 1'b0;
      rie_q <= 1'b0;
      rxd_q <= 1'b0;
    end else begin
      bal_q <= bal_n;
      cnt_q <= cnt_n;
      bah_q <= bah_n;
      cie_q <= cie_n;
      rie_q <= rie_n;
      rxd_q <= rxd_n;
    end
  end

  always_comb begin
    case (bus_word)
      W_CSR:   bus_rdata = {1'b0, busy, last_code, cmd_done, cie_q, rxd_q, rie_q, status};
      W_BAH:   bus_rdata = {{(BUS_W-XA_W){1'b0}}, bah_q};
      default: bus_rdata = '0;
    endcase
  end

  a_r11_rx_done_set: assert property (@(posedge clk) disable iff (!rst_s)
    (rx_event && rx_desc_valid && !wr_csr) |=> (rxd_q && irq_rx == rie_q));

  a_r7_reset_cmd: assert property (@(posedge clk) disable iff (!rst_s)
    do_reset |=> (!rx_desc_valid && !rxd_q && bah_q == '0 && status == ST_OK));

  a_r4_push_lands: assert property (@(posedge clk) disable iff (!rst_s)
    (do_push && !rx_desc_valid && !rx_event) |=> (rx_desc_valid &&
      rx_desc_addr == $past({bah_q, bal_q}) && rx_desc_len == $past(cnt_q)));

endmodule

// File: tb/nic_cmd_frontend_tb_top.sv
module nic_cmd_frontend_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [8:0] VB = 9'o340;

  logic        clk, rst_n, bus_wr, be_done, rx_event;
  logic [1:0]  bus_word;
  logic [15:0] bus_wdata, bus_rdata;
  logic        be_cmd_valid, rx_desc_valid, irq_cmd, irq_rx;
  logic [5:0]  be_cmd_code;
  logic [3:0]  be_status;
  logic [21:0] rx_desc_addr;
  logic [15:0] rx_desc_len;
  logic [8:0]  irq_vector;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  nic_cmd_frontend dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_word(bus_word),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .be_cmd_valid(be_cmd_valid), .be_cmd_code(be_cmd_code),
    .be_done(be_done), .be_status(be_status), .rx_event(rx_event),
    .rx_desc_valid(rx_desc_valid), .rx_desc_addr(rx_desc_addr),
    .rx_desc_len(rx_desc_len), .irq_cmd(irq_cmd), .irq_rx(irq_rx),
    .irq_vector(irq_vector)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // {code[14:9], remote[8], be_status[7:4], expected status[3:0]}
  localparam int NV = 10;
  localparam logic [14:0] VEC [NV] = '{
    {6'o13, 1'b0, 4'd0,  4'd2},
    {6'o24, 1'b0, 4'd0,  4'd2},
    {6'o70, 1'b0, 4'd0,  4'd2},
    {6'o41, 1'b0, 4'd0,  4'd2},
    {6'o60, 1'b0, 4'd0,  4'd0},
    {6'o01, 1'b1, 4'd0,  4'd0},
    {6'o11, 1'b1, 4'd1,  4'd1},
    {6'o30, 1'b1, 4'd15, 4'd15},
    {6'o51, 1'b1, 4'd4,  4'd4},
    {6'o12, 1'b1, 4'd0,  4'd0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] mkcsr(input logic g, input logic [5:0] c,
                                        input logic cie, input logic keep, input logic rie);
    return {g, 1'b0, c, 1'b0, cie, keep, rie, 4'd0};
  endfunction

  task automatic wr(input logic [1:0] w, input logic [15:0] d);
    @(negedge clk);
    bus_word = w; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] w, output logic [15:0] d);
    bus_word = w;
    #1;
    d = bus_rdata;
  endtask

  task automatic pulse_rx();
    @(negedge clk);
    rx_event = 1'b1;
    @(negedge clk);
    rx_event = 1'b0;
  endtask

  task automatic finish_be(input logic [3:0] s);
    @(negedge clk);
    be_done = 1'b1; be_status = s;
    @(negedge clk);
    be_done = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] r;
    rst_n = 1'b0; bus_wr = 1'b0; bus_word = 2'd0; bus_wdata = '0;
    be_done = 1'b0; be_status = '0; rx_event = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    rd(2'd0, r);
    chk("R1 csr reset", r, 16'h0000);
    chk("R1 irq reset", {irq_cmd, irq_rx, rx_desc_valid, be_cmd_valid}, 4'b0000);

    // R2 write-only registers, R3 high address mask
    wr(2'd1, 16'hBEEF); wr(2'd2, 16'h1234); wr(2'd3, 16'hFFFF);
    rd(2'd1, r); chk("R2 addr low reads 0", r, 16'h0);
    rd(2'd2, r); chk("R2 count reads 0", r, 16'h0);
    rd(2'd3, r); chk("R3 addr high mask", r, 16'h003F);

    // R8 R9 R6 vector table
    for (int i = 0; i < NV; i++) begin
      logic [5:0] c;
      c = VEC[i][14:9];
      wr(2'd0, mkcsr(1'b1, c, 1'b0, 1'b0, 1'b0));
      rd(2'd0, r);
      if (VEC[i][8]) begin
        chk("R9 request pulse", {be_cmd_valid, be_cmd_code}, {1'b1, c});
        chk("R10 done cleared busy set", {r[14], r[7]}, 2'b10);
        finish_be(VEC[i][7:4]);
        rd(2'd0, r);
        chk("R9 completion status", {r[14], r[13:8], r[7], r[3:0]},
            {1'b0, c, 1'b1, VEC[i][3:0]});
      end else begin
        chk("R8 immediate completion", {be_cmd_valid, r[14], r[13:8], r[7], r[3:0]},
            {1'b0, 1'b0, c, 1'b1, VEC[i][3:0]});
      end
    end

    // R9 go write while busy ignored
    wr(2'd0, mkcsr(1'b1, 6'o01, 1'b0, 1'b0, 1'b0));
    wr(2'd0, mkcsr(1'b1, 6'o13, 1'b0, 1'b0, 1'b0));
    rd(2'd0, r);
    chk("R9 busy ignores go", {r[14], r[13:8], r[7], be_cmd_valid}, {1'b1, 6'o01, 1'b0, 1'b0});
    finish_be(4'd1);
    rd(2'd0, r);
    chk("R9 status after busy", {r[14], r[7], r[3:0]}, {1'b0, 1'b1, 4'd1});

    // R4 fill queue to sixteen
    for (int i = 0; i < 16; i++) begin
      wr(2'd1, 16'h1000 + 16'(i));
      wr(2'd2, 16'h0100 + 16'(i));
      wr(2'd3, 16'(i));
      wr(2'd0, mkcsr(1'b1, 6'o40, 1'b0, 1'b0, 1'b0));
      rd(2'd0, r);
      chk("R4 push status", {r[7], r[3:0]}, {1'b1, 4'd0});
    end
    chk("R4 head after fill", {rx_desc_valid, rx_desc_addr, rx_desc_len},
        {1'b1, 6'd0, 16'h1000, 16'h0100});

    // R5 seventeenth push refused
    wr(2'd1, 16'hAAAA);
    wr(2'd0, mkcsr(1'b1, 6'o40, 1'b0, 1'b0, 1'b0));
    rd(2'd0, r);
    chk("R5 full status", {r[7], r[3:0]}, {1'b1, 4'd3});
    chk("R5 head unchanged", {rx_desc_addr, rx_desc_len}, {6'd0, 16'h1000, 16'h0100});

    // R11 drain in order
    for (int i = 0; i < 16; i++) begin
      chk("R11 order", {rx_desc_valid, rx_desc_addr, rx_desc_len},
          {1'b1, 6'(i), 16'h1000 + 16'(i), 16'h0100 + 16'(i)});
      pulse_rx();
    end
    rd(2'd0, r);
    chk("R11 rx done set, empty", {r[5], rx_desc_valid}, 2'b10);
    wr(2'd0, mkcsr(1'b0, 6'o00, 1'b0, 1'b0, 1'b0));
    rd(2'd0, r);
    chk("R11 host clears rx done", r[5], 1'b0);
    pulse_rx();
    rd(2'd0, r);
    chk("R11 empty pop ignored", {r[5], rx_desc_valid}, 2'b00);

    // R12 R10 interrupts; command done still set from the refused push
    wr(2'd0, mkcsr(1'b0, 6'o00, 1'b1, 1'b0, 1'b0));
    rd(2'd0, r);
    chk("R10 plain write keeps done", {r[7], r[3:0], r[6]}, {1'b1, 4'd3, 1'b1});
    chk("R12 cmd irq vector", {irq_cmd, irq_rx, irq_vector}, {1'b1, 1'b0, VB + 9'd4});
    wr(2'd0, mkcsr(1'b1, 6'o40, 1'b1, 1'b0, 1'b0));
    pulse_rx();
    chk("R12 rx done without enable", {irq_rx, irq_vector}, {1'b0, VB + 9'd4});
    wr(2'd0, mkcsr(1'b0, 6'o00, 1'b1, 1'b1, 1'b1));
    chk("R12 rx priority", {irq_cmd, irq_rx, irq_vector}, {1'b1, 1'b1, VB});
    wr(2'd0, mkcsr(1'b0, 6'o00, 1'b1, 1'b0, 1'b1));
    chk("R12 rx cleared", {irq_cmd, irq_rx, irq_vector}, {1'b1, 1'b0, VB + 9'd4});
    wr(2'd0, mkcsr(1'b0, 6'o00, 1'b0, 1'b0, 1'b0));
    chk("R12 no request", {irq_cmd, irq_rx, irq_vector}, {1'b0, 1'b0, VB});

    // R6 flush
    wr(2'd0, mkcsr(1'b1, 6'o40, 1'b0, 1'b0, 1'b0));
    wr(2'd0, mkcsr(1'b1, 6'o40, 1'b0, 1'b0, 1'b0));
    chk("R6 queue loaded", rx_desc_valid, 1'b1);
    wr(2'd0, mkcsr(1'b1, 6'o60, 1'b0, 1'b0, 1'b0));
    rd(2'd0, r);
    chk("R6 flush empties", {rx_desc_valid, r[7], r[3:0]}, {1'b0, 1'b1, 4'd0});

    // R7 reset command
    wr(2'd3, 16'h0015);
    wr(2'd0, mkcsr(1'b1, 6'o40, 1'b0, 1'b0, 1'b0));
    wr(2'd0, mkcsr(1'b1, 6'o40, 1'b0, 1'b0, 1'b0));
    pulse_rx();
    rd(2'd0, r);
    chk("R7 setup", {r[5], rx_desc_valid}, 2'b11);
    wr(2'd0, mkcsr(1'b1, 6'o77, 1'b0, 1'b1, 1'b0));
    rd(2'd0, r);
    chk("R7 reset clears", {rx_desc_valid, r[5], r[7], r[3:0]}, {1'b0, 1'b0, 1'b1, 4'd0});
    rd(2'd3, r);
    chk("R7 addr high cleared", r, 16'h0);
    wr(2'd0, mkcsr(1'b1, 6'o40, 1'b0, 1'b0, 1'b0));
    chk("R7 address regs cleared", {rx_desc_valid, rx_desc_addr, rx_desc_len}, {1'b1, 22'd0, 16'd0});

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule